// File: doc/BRIEF.md
# Bus-Mapped Integer Divider

This block is a register-mapped integer divider for a processor bus. Software writes a dividend and a divisor, then reads back a quotient and a remainder. Each operand has two addresses that reach the same storage. One address requests unsigned division and the other requests signed division. Any write to an operand address starts a new multi-cycle division on the current pair of operands. Sign or no sign is decided by the address of that latest write.

The result registers can also be written directly. A direct write stops any division in progress, so software can save and restore the divider across a context switch. A status word has two flags. The ready flag shows that the results are valid. The dirty flag shows that the divider holds state a context switch must save. Reading the quotient clears the dirty flag, so software reads the remainder first and the quotient last.

Inside, a restoring shift-subtract engine works on operand magnitudes for `WIDTH` iterations. Signs are applied to the results at the end. Bus reads are combinational from the address. A read side effect (dirty clearing) happens only when the access is selected.

Top module: `bus_divider`

## Requirements
- R1: Word address 0 is the unsigned dividend and address 2 is the signed dividend; they share one register. Address 1 is the unsigned divisor and address 3 is the signed divisor; they also share one register. Each address reads back the shared register.
- R2: A write to any of addresses 0 to 3 restarts the division on the updated operand pair. It clears ready and sets dirty on that clock edge. Ready rises exactly `WIDTH`+1 clock edges after the write edge, unless an abort comes first.
- R3: After an unsigned division with a non-zero divisor, the quotient register (address 4) holds floor(n/d) and the remainder register (address 5) holds n mod d.
- R4: After a signed division with a non-zero divisor, the quotient is truncated toward zero and is negative exactly when the operand signs differ. The remainder has the sign of the dividend.
- R5: With a zero divisor, the remainder equals the dividend. The quotient is all ones in unsigned mode. In signed mode the quotient is 1 for a negative dividend and all ones otherwise.
- R6: Signed division of the most negative value by -1 gives the most negative value as the quotient and 0 as the remainder.
- R7: A write to address 4 or 5 loads that register with the write data, stops any running division, and sets both ready and dirty. The stopped division never overwrites either result register afterwards.
- R8: A selected read of address 4 clears dirty. Reads of any other address leave dirty unchanged.
- R9: Address 6 reads as status: bit 0 is ready, bit 1 is dirty, and all other bits are zero. Writes to address 6 change nothing.
- R10: After reset, ready is 1, dirty is 0, and the operand and result registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational from bus_addr |

## Verification
Suppose the iteration counter or the engine state is wrong. Then ready rises too early or too late, and the status word shows this within one cycle of the expected `WIDTH`+1 edge. A wrong magnitude, sign flag or partial remainder shows as a wrong quotient or remainder on the first read after ready. A sweep over every operand pair at a narrow width reaches the zero-divisor and overflow corners directly. A flag that is set or cleared by the wrong access shows in the status word on the very next cycle. A stopped engine that still commits shows as a result register changing after a direct write.

// File: rtl/div_pkg.sv
package div_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_UDVD = 3'd0,
    A_UDVS = 3'd1,
    A_SDVD = 3'd2,
    A_SDVS = 3'd3,
    A_QUO  = 3'd4,
    A_REM  = 3'd5,
    A_STAT = 3'd6
  } div_addr_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_FIX  = 2'd2
  } eng_state_t;

  typedef struct packed {
    logic op_wr;       // write to any operand alias
    logic dvd_sel;     // operand write targets the dividend
    logic signed_op;   // operand write came through a signed alias
    logic quo_wr;      // direct write of quotient
    logic rem_wr;      // direct write of remainder
    logic quo_rd;      // selected read of quotient
  } div_dec_t;

endpackage

// File: rtl/div_rst_sync.sv
module div_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];

endmodule

// File: rtl/div_decode.sv
module div_decode
  import div_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output div_dec_t          dec
);

  logic wr_stb;
  logic rd_stb;

  always_comb begin
    wr_stb        = bus_sel & bus_wr;
    rd_stb        = bus_sel & ~bus_wr;
    dec           = '0;
    dec.dvd_sel   = (bus_addr == A_UDVD) | (bus_addr == A_SDVD);
    dec.signed_op = (bus_addr == A_SDVD) | (bus_addr == A_SDVS);
    dec.op_wr     = wr_stb & ((bus_addr == A_UDVD) | (bus_addr == A_UDVS) |
                              (bus_addr == A_SDVD) | (bus_addr == A_SDVS));
    dec.quo_wr    = wr_stb & (bus_addr == A_QUO);
    dec.rem_wr    = wr_stb & (bus_addr == A_REM);
    dec.quo_rd    = rd_stb & (bus_addr == A_QUO);
  end

endmodule

// File: rtl/div_engine.sv
module div_engine
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             start,
  input  logic             signed_mode,
  input  logic             abort,
  input  logic [WIDTH-1:0] dvd_in,
  input  logic [WIDTH-1:0] dvs_in,
  output logic             done,
  output logic [WIDTH-1:0] quo_res,
  output logic [WIDTH-1:0] rem_res
);

  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  eng_state_t       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [WIDTH-1:0] acc_q, acc_n;   // dividend shifting out, quotient shifting in
  logic [WIDTH-1:0] par_q, par_n;   // partial remainder
  logic [WIDTH-1:0] dsr_q, dsr_n;   // divisor magnitude
  logic             negq_q, negq_n;
  logic             negr_q, negr_n;
  logic             en;

  logic [WIDTH:0]   shifted;
  logic [WIDTH+1:0] diff;
  logic             take;
  logic             dvd_neg;
  logic             dvs_neg;

  always_comb begin
    dvd_neg = signed_mode & dvd_in[WIDTH-1];
    dvs_neg = signed_mode & dvs_in[WIDTH-1];
    shifted = {par_q, acc_q[WIDTH-1]};
    diff    = {1'b0, shifted} - {2'b00, dsr_q};
    take    = ~diff[WIDTH+1];

    st_n   = st_q;
    cnt_n  = cnt_q;
    acc_n  = acc_q;
    par_n  = par_q;
    dsr_n  = dsr_q;
    negq_n = negq_q;
    negr_n = negr_q;
    en     = start | abort | (st_q != S_IDLE);

    if (start) begin
      st_n   = S_RUN;
      cnt_n  = '0;
      acc_n  = dvd_neg ? -dvd_in : dvd_in;
      par_n  = '0;
      dsr_n  = dvs_neg ? -dvs_in : dvs_in;
      negq_n = dvd_neg ^ dvs_neg;
      negr_n = dvd_neg;
    end else if (abort) begin
      st_n = S_IDLE;
    end else begin
      case (st_q)
        S_RUN: begin
          par_n = take ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
          acc_n = {acc_q[WIDTH-2:0], take};
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST) st_n = S_FIX;
        end
        S_FIX:   st_n = S_IDLE;
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      acc_q  <= '0;
      par_q  <= '0;
      dsr_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else if (en) begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      acc_q  <= acc_n;
      par_q  <= par_n;
      dsr_q  <= dsr_n;
      negq_q <= negq_n;
      negr_q <= negr_n;
    end
  end

  assign done    = (st_q == S_FIX);
  assign quo_res = negq_q ? -acc_q : acc_q;
  assign rem_res = negr_q ? -par_q : par_q;

endmodule

// File: rtl/div_flags.sv
module div_flags (
  input  logic clk,
  input  logic rst_ns,
  input  logic op_wr,
  input  logic res_wr,
  input  logic commit,
  input  logic quo_rd,
  output logic ready,
  output logic dirty
);

  logic ready_n, dirty_n, en;

  always_comb begin
    ready_n = ready;
    dirty_n = dirty;
    en      = op_wr | res_wr | commit | quo_rd;
    if (res_wr)      ready_n = 1'b1;
    else if (op_wr)  ready_n = 1'b0;
    else if (commit) ready_n = 1'b1;
    if (op_wr | res_wr) dirty_n = 1'b1;
    else if (quo_rd)    dirty_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ready <= 1'b1;
      dirty <= 1'b0;
    end else if (en) begin
      ready <= ready_n;
      dirty <= dirty_n;
    end
  end

endmodule

// File: rtl/bus_divider.sv
module bus_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata
);

  logic             rst_ns;
  div_dec_t         dec;
  logic [WIDTH-1:0] dvd_q, dvd_n, dvs_q, dvs_n;
  logic [WIDTH-1:0] quo_q, quo_n, rem_q, rem_n;
  logic [WIDTH-1:0] eng_quo, eng_rem;
  logic             eng_done, commit, res_wr;
  logic             ready_w, dirty_w;
  logic             opr_en, res_en;

  div_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  div_decode u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .dec      (dec)
  );

  // operand next values feed the engine on the same edge they are stored
  always_comb begin
    dvd_n  = (dec.op_wr &  dec.dvd_sel) ? bus_wdata : dvd_q;
    dvs_n  = (dec.op_wr & ~dec.dvd_sel) ? bus_wdata : dvs_q;
    opr_en = dec.op_wr;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      dvd_q <= '0;
      dvs_q <= '0;
    end else if (opr_en) begin
      dvd_q <= dvd_n;
      dvs_q <= dvs_n;
    end
  end

  div_engine #(.WIDTH(WIDTH)) u_eng (
    .clk         (clk),
    .rst_ns      (rst_ns),
    .start       (dec.op_wr),
    .signed_mode (dec.signed_op),
    .abort       (res_wr),
    .dvd_in      (dvd_n),
    .dvs_in      (dvs_n),
    .done        (eng_done),
    .quo_res     (eng_quo),
    .rem_res     (eng_rem)
  );

  always_comb begin
    res_wr = dec.quo_wr | dec.rem_wr;
    commit = eng_done & ~res_wr & ~dec.op_wr;
    quo_n  = dec.quo_wr ? bus_wdata : eng_quo;
    rem_n  = dec.rem_wr ? bus_wdata : eng_rem;
    res_en = res_wr | commit;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      quo_q <= '0;
      rem_q <= '0;
    end else if (res_en) begin
      if (dec.quo_wr | commit) quo_q <= quo_n;
      if (dec.rem_wr | commit) rem_q <= rem_n;
    end
  end

  div_flags u_flags (
    .clk    (clk),
    .rst_ns (rst_ns),
    .op_wr  (dec.op_wr),
    .res_wr (res_wr),
    .commit (commit),
    .quo_rd (dec.quo_rd),
    .ready  (ready_w),
    .dirty  (dirty_w)
  );

  always_comb begin
    case (bus_addr)
      A_UDVD, A_SDVD: bus_rdata = dvd_q;
      A_UDVS, A_SDVS: bus_rdata = dvs_q;
      A_QUO:          bus_rdata = quo_q;
      A_REM:          bus_rdata = rem_q;
      A_STAT:         bus_rdata = {{(WIDTH-2){1'b0}}, dirty_w, ready_w};
      default:        bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/bus_divider_chk.sv
module bus_divider_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_ns,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic             rdy,
  input logic             dirty,
  input logic [WIDTH-1:0] quo,
  input logic [WIDTH-1:0] rem,
  input logic [WIDTH-1:0] dvd,
  input logic [WIDTH-1:0] dvs
);

  localparam int CW = $clog2(WIDTH + 3) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic op_wr, res_wr, quo_rd, stat_wr;
  logic umode;
  logic [CW-1:0] cnt;
  logic [WIDTH-1:0] recon;

  assign op_wr   = bus_sel & bus_wr & (bus_addr < 3'd4);
  assign res_wr  = bus_sel & bus_wr & ((bus_addr == 3'd4) | (bus_addr == 3'd5));
  assign quo_rd  = bus_sel & ~bus_wr & (bus_addr == 3'd4);
  assign stat_wr = bus_sel & bus_wr & (bus_addr == 3'd6);
  assign recon   = quo * dvs + rem;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cnt   <= '0;
      umode <= 1'b1;
    end else if (op_wr) begin
      cnt   <= '0;
      umode <= ~bus_addr[1];
    end else if (cnt != CMAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  op_start_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    op_wr |=> (!rdy && dirty));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ($rose(rdy) && !$past(res_wr)) |-> (cnt == CW'(WIDTH + 1)));

  // R3
  udiv_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ($rose(rdy) && !$past(res_wr) && umode) |->
      (recon == dvd && (dvs == '0 || rem < dvs)));

  // R7
  res_load_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    res_wr |=> (rdy && dirty));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!rdy && !res_wr) |=> ($stable(quo) || rdy));

  // R8
  quo_rd_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    quo_rd |=> !dirty);

  // R9
  stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (stat_wr && rdy) |=> (rdy && $stable(dirty)));

endmodule

bind bus_divider bus_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .rdy      (ready_w),
  .dirty    (dirty_w),
  .quo      (quo_q),
  .rem      (rem_q),
  .dvd      (dvd_q),
  .dvs      (dvs_q)
);

// File: tb/bus_divider_test.sv
module bus_divider_test;

  localparam int W = 5;
  localparam logic [2:0] UDVD = 3'd0, UDVS = 3'd1, SDVD = 3'd2, SDVS = 3'd3,
                         QUO = 3'd4, REM = 3'd5, STAT = 3'd6;

  logic         clk;
  logic         rst_n;
  logic         sel;
  logic         wr;
  logic [2:0]   addr;
  logic [W-1:0] wdata;
  logic [W-1:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  bus_divider #(.WIDTH(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (sel),
    .bus_wr    (wr),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [W-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_ready();
    logic [W-1:0] s;
    peek(STAT, s);
    for (int i = 0; i < 60 && !s[0]; i++) begin
      @(negedge clk);
      peek(STAT, s);
    end
    if (!s[0]) check("R2 ready timeout", 0, 1);
  endtask

  function automatic void model(input int n, input int d, input bit sg,
                                output logic [W-1:0] q, output logic [W-1:0] r);
    int sn, sd;
    if (!sg) begin
      if (d == 0) begin q = '1; r = W'(n); end
      else begin q = W'(n / d); r = W'(n % d); end
    end else begin
      sn = (n >= 2**(W-1)) ? n - 2**W : n;
      sd = (d >= 2**(W-1)) ? d - 2**W : d;
      if (sd == 0) begin q = (sn < 0) ? W'(1) : '1; r = W'(n); end
      else begin q = W'(sn / sd); r = W'(sn % sd); end
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] v, q, r, eq, er;
    string tag;
    sel = 1'b0; wr = 1'b0; addr = 3'd0; wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    peek(STAT, v); check("R10 status", v, 1);
    peek(QUO, v);  check("R10 quotient", v, 0);
    peek(REM, v);  check("R10 remainder", v, 0);
    peek(UDVD, v); check("R10 dividend", v, 0);
    peek(UDVS, v); check("R10 divisor", v, 0);

    // R2 exact latency, divisor still zero -> R5
    bus_write(UDVD, 5'd13);
    peek(STAT, v); check("R2 busy after write", v, 2);
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      peek(STAT, v); check("R2 still busy", v, 2);
    end
    @(negedge clk);
    peek(STAT, v); check("R2 ready on time", v, 3);
    bus_read(REM, v);  check("R5 unsigned rem", v, 13);
    bus_read(STAT, v); check("R8 status read keeps dirty", v, 3);
    peek(STAT, v);     check("R8 remainder read keeps dirty", v, 3);
    bus_read(QUO, v);  check("R5 unsigned quo", v, 31);
    peek(STAT, v);     check("R8 quotient read clears dirty", v, 1);

    // R1 aliases share storage
    bus_write(SDVD, 5'd9);
    peek(UDVD, v); check("R1 dividend alias", v, 9);
    peek(SDVD, v); check("R1 dividend alias", v, 9);
    bus_write(SDVS, 5'd26);
    peek(UDVS, v); check("R1 divisor alias", v, 26);
    wait_ready();
    bus_read(REM, v); check("R4 9 rem -6", v, 3);
    bus_read(QUO, v); check("R4 9 div -6", v, 31);

    // R9 status write ignored
    bus_write(STAT, 5'd0);
    peek(STAT, v); check("R9 status write ignored", v, 1);
    bus_write(STAT, 5'd2);
    peek(STAT, v); check("R9 status write ignored", v, 1);

    // R7 abort by direct result writes
    bus_write(UDVS, 5'd7);
    repeat (2) @(negedge clk);
    bus_write(QUO, 5'h0A);
    peek(STAT, v); check("R7 abort sets flags", v, 3);
    bus_write(REM, 5'h15);
    repeat (W + 4) @(negedge clk);
    peek(QUO, v);  check("R7 quotient kept", v, 5'h0A);
    peek(REM, v);  check("R7 remainder kept", v, 5'h15);
    peek(STAT, v); check("R7 flags kept", v, 3);
    bus_read(QUO, v);
    peek(STAT, v); check("R8 clear after restore", v, 1);

    // R3 R4 R5 R6 full sweep, restart on divisor write
    for (int sg = 0; sg < 2; sg++) begin
      for (int n = 0; n < 2**W; n++) begin
        for (int d = 0; d < 2**W; d++) begin
          bus_write((n % 2) ? SDVD : UDVD, W'(n));
          bus_write(sg ? SDVS : UDVS, W'(d));
          wait_ready();
          bus_read(REM, r);
          bus_read(QUO, q);
          model(n, d, sg[0], eq, er);
          if (d == 0) tag = "R5";
          else if (sg == 1 && n == 2**(W-1) && d == 2**W - 1) tag = "R6";
          else if (sg == 1) tag = "R4";
          else tag = "R3";
          check({tag, " remainder"}, r, er);
          check({tag, " quotient"}, q, eq);
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule